// File: doc/BRIEF.md
# Eight-Lane Pseudo-Modular Add/Subtract Unit

This unit is a purely combinational datapath for a wide-word arithmetic engine. It splits two 256-bit source words into eight unsigned 32-bit lanes and either adds or subtracts them lane by lane. It decodes the operation from the instruction word it is given.

In modular mode each lane applies one conditional correction against a 32-bit modulus q, which is taken from the low word of a 256-bit modulus register. A lane sum at or above q has q removed once. A negative lane difference has q added once. This gives correct modular arithmetic when both operands are already below q. It also reduces a value in [0, 2q) to [0, q) when the other operand is zero.

No carry or flag state is read or produced. An instruction word with an unsupported element-length code or a wrong minor opcode raises an illegal-encoding output and forces the result to zero.

The block moves no data stream across a clock boundary, so it has no valid/ready handshake. Its result is valid in the same cycle as its inputs.

Top module: `simd_pmod_addsub`

## Requirements
- R1: Lane i (i = 0..7) of every operand and of the result occupies bits [32*i+31 : 32*i]; lanes are computed independently of each other.
- R2: With instruction bit 30 = 0 and bit 28 = 0, each result lane is (a + b) mod 2^32.
- R3: With bit 30 = 1 and bit 28 = 0, each result lane is (a - b) mod 2^32.
- R4: With bit 30 = 0 and bit 28 = 1, the full 33-bit lane sum is compared with q; if sum >= q the lane is (sum - q) mod 2^32, otherwise sum mod 2^32.
- R5: With bit 30 = 1 and bit 28 = 1, the lane difference is taken as signed; if it is negative the lane is (a - b + q) mod 2^32, otherwise (a - b) mod 2^32.
- R6: q is bits [31:0] of the modulus input; bits [255:32] of the modulus input have no effect on the result.
- R7: Decode reads only bit 30 (subtract), bit 28 (modular), bits 26:25 (element length, 00 = 32-bit lanes) and bits 14:12 (minor opcode, must be 000); all other instruction bits have no effect.
- R8: If bits 26:25 are not 00 or bits 14:12 are not 000, illegal_o is 1 and result_o is all zero; otherwise illegal_o is 0.
- R9: The unit holds no state; result_o and illegal_o follow the inputs in the same cycle.
- R10: In modular add mode with one operand lane 0 and the other in [0, 2q), the result lane lies in [0, q).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word carrying the operation fields |
| src_a_i | input | 256 | First source vector (minuend for subtraction) |
| src_b_i | input | 256 | Second source vector (subtrahend for subtraction) |
| mod_reg_i | input | 256 | Wide modulus register; q is its low 32 bits |
| result_o | output | 256 | Lane-wise result vector |
| illegal_o | output | 1 | High when the instruction word has an unsupported encoding |

## Verification
Both outputs are due in the same cycle as the inputs that produce them, with no register on the path. The bench applies each stimulus one nanosecond after a rising edge. It samples at the following falling edge, half a period later, once every input has settled. It never looks at the outputs near the active edge. Each sample is compared with a lane-wise model in the bench that uses 64-bit signed arithmetic, so the 33-bit comparison and the signed test are computed separately from the design.

// File: rtl/simd_pmod_pkg.sv
package simd_pmod_pkg;

  // Instruction field positions used by the decoder
  localparam int unsigned SubBitPos     = 30;
  localparam int unsigned ModBitPos     = 28;
  localparam int unsigned ElenLsbPos    = 25;
  localparam int unsigned ElenWidth     = 2;
  localparam int unsigned MinorLsbPos   = 12;
  localparam int unsigned MinorWidth    = 3;

  // Supported codes
  localparam logic [ElenWidth-1:0]  ElenCode32 = 2'b00;
  localparam logic [MinorWidth-1:0] MinorCodeVec = 3'b000;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MADD = 2'b10,
    OP_MSUB = 2'b11
  } lane_op_e;

  typedef struct packed {
    logic     illegal;
    lane_op_e op;
  } vec_ctl_t;

endpackage

// File: rtl/simd_pmod_decode.sv
module simd_pmod_decode
  import simd_pmod_pkg::*;
(
  input  logic [31:0] instr_i,
  output vec_ctl_t    ctl_o
);

  logic                  want_sub;
  logic                  want_mod;
  logic [ElenWidth-1:0]  elen_field;
  logic [MinorWidth-1:0] minor_field;

  always_comb begin
    want_sub    = instr_i[SubBitPos];
    want_mod    = instr_i[ModBitPos];
    elen_field  = instr_i[ElenLsbPos +: ElenWidth];
    minor_field = instr_i[MinorLsbPos +: MinorWidth];
    ctl_o.op      = lane_op_e'({want_mod, want_sub});
    ctl_o.illegal = (elen_field != ElenCode32) || (minor_field != MinorCodeVec);
  end

  // p_legal_codes_r8: a legal decode always carries the supported codes
  always_comb begin
    if (!ctl_o.illegal) begin
      p_legal_codes_r8: assert (instr_i[26:25] == 2'b00 && instr_i[14:12] == 3'b000)
        else $error("p_legal_codes_r8 violated");
    end
  end

endmodule

// File: rtl/simd_pmod_lane.sv
module simd_pmod_lane
  import simd_pmod_pkg::*;
#(
  parameter int unsigned LANE_W = 32
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] q_i,
  input  lane_op_e          op_i,
  output logic [LANE_W-1:0] res_o
);

  localparam int unsigned WideW = LANE_W + 1;
  localparam int unsigned ChkW  = LANE_W + 2;

  logic [WideW-1:0] sum_w;
  logic [WideW-1:0] diff_w;
  logic [WideW-1:0] q_w;
  logic             sum_ge_q;
  logic             diff_neg;
  logic [LANE_W-1:0] add_fix;
  logic [LANE_W-1:0] sub_fix;

  always_comb begin
    q_w      = {1'b0, q_i};
    sum_w    = {1'b0, a_i} + {1'b0, b_i};
    diff_w   = {1'b0, a_i} - {1'b0, b_i};
    sum_ge_q = (sum_w >= q_w);
    diff_neg = diff_w[LANE_W];
    add_fix  = sum_ge_q ? (sum_w[LANE_W-1:0] - q_i) : sum_w[LANE_W-1:0];
    sub_fix  = diff_neg ? (diff_w[LANE_W-1:0] + q_i) : diff_w[LANE_W-1:0];
    unique case (op_i)
      OP_ADD:  res_o = sum_w[LANE_W-1:0];
      OP_SUB:  res_o = diff_w[LANE_W-1:0];
      OP_MADD: res_o = add_fix;
      default: res_o = sub_fix;
    endcase
  end

  // Range checks use wider arithmetic than the datapath
  logic [ChkW-1:0] chk_sum;
  logic [ChkW-1:0] chk_twice_q;
  always_comb begin
    chk_sum     = {2'b00, a_i} + {2'b00, b_i};
    chk_twice_q = {1'b0, q_i, 1'b0};
  end

  always_comb begin
    if (op_i == OP_ADD) begin
      p_add_inverse_r2: assert ((res_o - b_i) == a_i)
        else $error("p_add_inverse_r2 violated");
    end
    if (op_i == OP_SUB) begin
      p_sub_inverse_r3: assert ((res_o + b_i) == a_i)
        else $error("p_sub_inverse_r3 violated");
    end
    if (op_i == OP_MADD && q_i != '0 && chk_sum < chk_twice_q) begin
      p_madd_range_r4: assert (res_o < q_i)
        else $error("p_madd_range_r4 violated");
    end
    if (op_i == OP_MSUB && a_i < q_i && b_i < q_i) begin
      p_msub_range_r5: assert (res_o < q_i)
        else $error("p_msub_range_r5 violated");
    end
    if (op_i == OP_MADD && a_i == '0 && q_i != '0 && {1'b0, b_i} < {q_i, 1'b0}) begin
      p_reduce_r10: assert (res_o < q_i)
        else $error("p_reduce_r10 violated");
    end
  end

endmodule

// File: rtl/simd_pmod_addsub.sv
module simd_pmod_addsub
  import simd_pmod_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 8
) (
  input  logic [31:0]             instr_i,
  input  logic [LANE_W*LANES-1:0] src_a_i,
  input  logic [LANE_W*LANES-1:0] src_b_i,
  input  logic [LANE_W*LANES-1:0] mod_reg_i,
  output logic [LANE_W*LANES-1:0] result_o,
  output logic                    illegal_o
);

  localparam int unsigned DataW = LANE_W * LANES;

  vec_ctl_t          ctl;
  logic [DataW-1:0]  lane_res;
  logic [LANE_W-1:0] q_val;

  assign q_val = mod_reg_i[LANE_W-1:0];

  simd_pmod_decode u_decode (
    .instr_i (instr_i),
    .ctl_o   (ctl)
  );

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    simd_pmod_lane #(
      .LANE_W (LANE_W)
    ) u_lane (
      .a_i   (src_a_i[gi*LANE_W +: LANE_W]),
      .b_i   (src_b_i[gi*LANE_W +: LANE_W]),
      .q_i   (q_val),
      .op_i  (ctl.op),
      .res_o (lane_res[gi*LANE_W +: LANE_W])
    );
  end

  assign result_o  = ctl.illegal ? '0 : lane_res;
  assign illegal_o = ctl.illegal;

  // p_illegal_zero_r8: an illegal encoding never leaks lane data
  always_comb begin
    if (illegal_o) begin
      p_illegal_zero_r8: assert (result_o == '0)
        else $error("p_illegal_zero_r8 violated");
    end
  end

endmodule

// File: tb/simd_pmod_addsub_test.sv
module simd_pmod_addsub_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0]  instr;
  logic [255:0] a, b, m;
  logic [255:0] result;
  logic         illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  simd_pmod_addsub uut (
    .instr_i   (instr),
    .src_a_i   (a),
    .src_b_i   (b),
    .mod_reg_i (m),
    .result_o  (result),
    .illegal_o (illegal)
  );

  function automatic logic [256:0] model(input logic [31:0] ins, input logic [255:0] x,
                                         input logic [255:0] y, input logic [255:0] mr);
    logic [255:0] r;
    longint q, s, xv, yv;
    if (ins[26:25] != 2'b00 || ins[14:12] != 3'b000) return {1'b1, 256'd0};
    q = longint'(mr[31:0]);
    r = '0;
    for (int i = 0; i < 8; i++) begin
      xv = longint'(x[32*i +: 32]);
      yv = longint'(y[32*i +: 32]);
      if (!ins[30]) begin
        s = xv + yv;
        if (ins[28] && s >= q) s = s - q;
      end else begin
        s = xv - yv;
        if (ins[28] && s < 0) s = s + q;
      end
      r[32*i +: 32] = s[31:0];
    end
    return {1'b0, r};
  endfunction

  function automatic logic [31:0] mk(input bit sub, input bit md, input logic [1:0] el,
                                     input logic [2:0] f3, input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[30] = sub;
    w[28] = md;
    w[26:25] = el;
    w[14:12] = f3;
    return w;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [255:0] x,
                       input logic [255:0] y, input logic [255:0] mr);
    @(posedge clk);
    #1;
    instr = ins; a = x; b = y; m = mr;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [256:0] exp;
    exp = model(instr, a, b, m);
    n_checks++;
    if ({illegal, result} !== exp) begin
      n_fail++;
      $display("FAIL %s: got ill=%0b res=%h expected ill=%0b res=%h",
               tag, illegal, result, exp[256], exp[255:0]);
    end
  endtask

  task automatic check_lane(input string tag, input int ln, input logic [31:0] exp);
    n_checks++;
    if (result[32*ln +: 32] !== exp) begin
      n_fail++;
      $display("FAIL %s: lane %0d got %h expected %h", tag, ln, result[32*ln +: 32], exp);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] x, y, mr;
    void'($urandom(32'd20240611));
    instr = '0; a = '0; b = '0; m = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9: idle state with all-zero inputs
    @(negedge clk);
    check_all("R9 zero inputs");

    // R1/R2: distinct lane values, plain add
    for (int i = 0; i < 8; i++) begin
      x[32*i +: 32] = 32'h1000_0000 * i + i;
      y[32*i +: 32] = 32'hF000_0000 + i;
    end
    apply(mk(0, 0, 2'b00, 3'b000, 32'h0), x, y, '0);
    check_all("R1 lane layout");
    check_lane("R2 add wrap", 1, 32'h0000_0002);

    // R3: plain subtract wraps
    x = '0; y = '0; y[31:0] = 32'd1;
    apply(mk(1, 0, 2'b00, 3'b000, 32'h0), x, y, '0);
    check_lane("R3 sub wrap", 0, 32'hFFFF_FFFF);

    // R4: sum exactly q gives 0, q-1 kept, 33-bit overflow
    mr = '0; mr[31:0] = 32'd100;
    x = '0; y = '0;
    x[31:0] = 32'd60; y[31:0] = 32'd40;
    x[63:32] = 32'd59; y[63:32] = 32'd40;
    apply(mk(0, 1, 2'b00, 3'b000, 32'h0), x, y, mr);
    check_lane("R4 sum equals q", 0, 32'd0);
    check_lane("R4 sum below q", 1, 32'd99);
    mr[31:0] = 32'hFFFF_FFFF;
    x = {8{32'hFFFF_FFFF}}; y = x;
    apply(mk(0, 1, 2'b00, 3'b000, 32'h0), x, y, mr);
    check_lane("R4 33-bit compare", 3, 32'hFFFF_FFFF);

    // R5: negative difference corrected, zero difference untouched
    mr = '0; mr[31:0] = 32'd7;
    x = '0; y = '0;
    x[31:0] = 32'd3; y[31:0] = 32'd5;
    x[63:32] = 32'd4; y[63:32] = 32'd4;
    apply(mk(1, 1, 2'b00, 3'b000, 32'h0), x, y, mr);
    check_lane("R5 negative", 0, 32'd5);
    check_lane("R5 zero diff", 1, 32'd0);

    // R6: upper modulus bits have no effect
    mr = {224'hDEAD_BEEF_0123_4567_89AB_CDEF_FFFF_FFFF_5555_AAAA_1234_5678_9999, 32'd7};
    apply(mk(1, 1, 2'b00, 3'b000, 32'h0), x, y, mr);
    check_lane("R6 upper modulus ignored", 0, 32'd5);

    // R7: unrelated instruction bits ignored
    apply(mk(1, 1, 2'b00, 3'b000, 32'hA5A5_8F7F), x, y, mr);
    check_lane("R7 junk bits ignored", 0, 32'd5);
    check_all("R7 junk bits full");

    // R8: illegal element length and minor opcode
    apply(mk(0, 0, 2'b01, 3'b000, 32'h0), rnd256(), rnd256(), rnd256());
    check_all("R8 elen 01");
    apply(mk(1, 1, 2'b11, 3'b000, 32'h0), rnd256(), rnd256(), rnd256());
    check_all("R8 elen 11");
    apply(mk(0, 1, 2'b00, 3'b101, 32'h0), rnd256(), rnd256(), rnd256());
    check_all("R8 minor opcode");

    // R10: zero plus value in [0,2q) reduces below q
    mr = '0; mr[31:0] = 32'd3329;
    x = '0;
    for (int i = 0; i < 8; i++) y[32*i +: 32] = 32'd3329 + 32'd950 * i - 32'd400;
    y[31:0] = 32'd6657;
    apply(mk(0, 1, 2'b00, 3'b000, 32'h0), x, y, mr);
    check_lane("R10 top of range", 0, 32'd3328);
    check_all("R10 reduction");

    // Random mix across all modes (R2 R3 R4 R5 R8)
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ins, qv;
      bit s, md;
      s  = $urandom_range(0, 1);
      md = $urandom_range(0, 1);
      ins = mk(s, md, ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
               ($urandom_range(0, 9) == 0) ? 3'($urandom_range(1, 7)) : 3'b000, $urandom);
      qv = (k % 2 == 0) ? $urandom : 32'($urandom_range(1, 8380417));
      mr = rnd256(); mr[31:0] = qv;
      x = rnd256(); y = rnd256();
      if (k % 2 == 0) begin
        for (int i = 0; i < 8; i++) begin
          x[32*i +: 32] = x[32*i +: 32] % qv;
          y[32*i +: 32] = y[32*i +: 32] % qv;
        end
      end
      apply(ins, x, y, mr);
      if (ins[26:25] != 2'b00 || ins[14:12] != 3'b000) check_all("R8 random");
      else if (!s && !md) check_all("R2 random");
      else if (s && !md)  check_all("R3 random");
      else if (!s && md)  check_all("R4 random");
      else                check_all("R5 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule